// File: doc/BRIEF.md
# Cascadable Quadrature Encoder Counter

This block is one 16-bit up/down counter channel. In normal mode it adds one for every clock cycle in which a count-enable input is high. In phase-counting mode it reads the two square-wave phases of an incremental encoder and turns every edge of either phase into one step up or one step down, depending on which phase leads. In cascade mode it counts the wrap pulses of a neighbouring channel. Two such channels, with the upper one in cascade mode, form a 32-bit position counter.

Two general registers sit beside the counter. Each one is either a compare register, which flags the step that lands the counter on its value, or a capture register, which copies the counter on a strobe. Sticky flags record compare or capture events, wrap-up, wrap-down and illegal encoder transitions. A small register port loads the counter and the general registers, reads them back and clears the flags.

Top module: `qenc_counter`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) the counter, both general registers and all five flags read zero.
- R2: With mode 2'b00 (normal) the counter grows by exactly one at every rising edge where cnt_en is high.
- R3: With mode 2'b01 (phase), {enc_a,enc_b} stepping through 00, 10, 11, 01, 00 (A leading) adds one per change and the reverse order subtracts one; a pin change shows in the counter at the third rising edge after it and not at the second.
- R4: In phase mode, a sample where both phases change together leaves the counter unchanged and sets flag bit 4 (illegal transition).
- R5: A step up from 16'hFFFF gives 16'h0000, sets flag bit 2 and drives ovf_out high in that cycle.
- R6: A step down from 16'h0000 gives 16'hFFFF, sets flag bit 3 and drives unf_out high in that cycle.
- R7: With mode 2'b10 (cascade) the counter adds one on each edge with casc_up high and subtracts one on each edge with casc_dn high; a second channel fed by ovf_out/unf_out carries the upper 16 bits of a 32-bit count.
- R8: A general register i whose gr_cap_mode[i] is 0 sets flag bit i when a count step makes the counter equal to its value.
- R9: A general register i whose gr_cap_mode[i] is 1 takes the counter value and sets flag bit i at the edge where cap_strobe[i] is high.
- R10: reg_addr 0 is the counter, 1 is general register 0, 2 is general register 1, 3 is the flags (read zero-extended; a write clears each flag whose data bit is 1); a counter write in the same cycle as a count step wins.
- R11: In normal mode the encoder pins have no effect on the counter, and in phase mode cnt_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 normal, 01 phase, 10 cascade, 11 hold |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cnt_en | input | 1 | Count enable in normal mode |
| casc_up | input | 1 | Lower channel wrap-up pulse in cascade mode |
| casc_dn | input | 1 | Lower channel wrap-down pulse in cascade mode |
| gr_cap_mode | input | 2 | Per general register: 1 capture, 0 compare |
| cap_strobe | input | 2 | Per general register capture strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq_flags | output | 5 | Sticky flags: bit0 GR0, bit1 GR1, bit2 wrap-up, bit3 wrap-down, bit4 illegal |
| ovf_out | output | 1 | Wrap-up pulse toward an upper channel |
| unf_out | output | 1 | Wrap-down pulse toward an upper channel |

## Verification
On every cycle the assertions check that the decoder never reports more than one of up, down and illegal, that the counter moves by at most one step and lands on the right value after a wrap, that flags stay set until cleared, that a capture takes the counter's previous value and that a mode blocks the inputs it does not use. Only the bench scenarios can show the direction rule for the encoder sequence, the exact three-edge pin latency, the 32-bit carry and borrow across two channels, the compare hit on the right step, and the write-over-count priority; a long random encoder walk crossing both wrap points is compared step by step with a bench model.

// File: rtl/qenc_pkg.sv
// Package: shared mode encoding, flag positions and register addresses
// for the encoder counter channel. Assumes two general registers.
package qenc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_PHASE   = 2'b01,
        MODE_CASCADE = 2'b10,
        MODE_HOLD    = 2'b11
    } qenc_mode_e;

    localparam int NUM_GR   = 2;
    localparam int FLAG_W   = 5;
    localparam int FLAG_OVF = 2;
    localparam int FLAG_UNF = 3;
    localparam int FLAG_ERR = 4;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_GR0  = 2'd1;
    localparam logic [1:0] ADDR_GR1  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;
endpackage

// File: rtl/qenc_sync.sv
// Module: multi-stage synchronizer for asynchronous inputs.
// Assumes each bit is independent; STAGES >= 1. Reset clears the chain.
module qenc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Purpose: shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_phase_dec.sv
// Module: 4x two-phase decoder. Compares the synchronized phase pair with
// the pair of the previous cycle. A single-phase change is one step; the
// direction is up when A leads B. A double change is illegal and no step.
// Assumes inputs are already synchronized to clk.
module qenc_phase_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    output logic step_up,
    output logic step_dn,
    output logic illegal
);
    logic [1:0] prev_q;
    logic [1:0] cur;
    logic [1:0] diff;

    assign cur  = {ph_a, ph_b};
    assign diff = cur ^ prev_q;

    // Purpose: remember the phase pair seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= cur;
    end

    // Purpose: classify the change as up, down, illegal or none.
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        illegal = 1'b0;
        if (diff == 2'b11) begin
            illegal = 1'b1;
        end else if (diff[1]) begin
            step_up = (cur[1] != cur[0]);
            step_dn = (cur[1] == cur[0]);
        end else if (diff[0]) begin
            step_up = (cur[1] == cur[0]);
            step_dn = (cur[1] != cur[0]);
        end
    end

    // R3: at most one classification per cycle
    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn, illegal}));
    // R4: an illegal change never counts
    assert_illegal_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!step_up && !step_dn));
endmodule

// File: rtl/qenc_count_core.sv
// Module: W-bit up/down counter with load. Load wins over a step; up and
// down together cancel. Wrap pulses are combinational so an upper channel
// steps on the same edge. Assumes at most one of up/dn from the caller.
module qenc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up,
    input  logic         dn,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         stepped,
    output logic         wrap_hi,
    output logic         wrap_lo
);
    localparam logic [W-1:0] MAX_VAL = '1;
    localparam logic [W-1:0] MIN_VAL = '0;

    logic [W-1:0] cnt_q;
    logic         go_up;
    logic         go_dn;

    assign go_up   = up && !dn && !ld;
    assign go_dn   = dn && !up && !ld;
    assign stepped = go_up || go_dn;
    assign wrap_hi = go_up && (cnt_q == MAX_VAL);
    assign wrap_lo = go_dn && (cnt_q == MIN_VAL);

    // Purpose: next counter value from load or step.
    always_comb begin
        cnt_next = cnt_q;
        if (ld)         cnt_next = ld_val;
        else if (go_up) cnt_next = cnt_q + 1'b1;
        else if (go_dn) cnt_next = cnt_q - 1'b1;
    end

    // Purpose: hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    assign cnt = cnt_q;

    // R5: wrap up lands on zero
    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_hi |=> (cnt == MIN_VAL));
    // R6: wrap down lands on all ones
    assert_wrap_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_lo |=> (cnt == MAX_VAL));
    // R2: a non-wrapping up step adds exactly one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_up && !wrap_hi) |=> (cnt == $past(cnt) + 1'b1));
    // R10: load overrides any step
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/qenc_gen_reg.sv
// Module: one general register, compare or capture. Compare fires when a
// step lands the counter on the stored value; capture copies the current
// counter on a strobe. A register write wins over a capture.
module qenc_gen_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         cap_strobe,
    input  logic         stepped,
    input  logic [W-1:0] cnt_cur,
    input  logic [W-1:0] cnt_next,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val,
    output logic         hit
);
    logic [W-1:0] val_q;
    logic         do_cap;

    assign do_cap = cap_mode && cap_strobe && !we;

    // Purpose: event for the flag, compare or capture depending on mode.
    always_comb begin
        if (cap_mode) hit = do_cap;
        else          hit = stepped && (cnt_next == val_q);
    end

    // Purpose: store written or captured value.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (we)     val_q <= wdata;
        else if (do_cap) val_q <= cnt_cur;
    end

    assign val = val_q;

    // R9: a capture holds the counter value of the strobe cycle
    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_cap |=> (val == $past(cnt_cur)));
    // R8: a compare register is only changed by writes
    assert_compare_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode && !we) |=> $stable(val));
endmodule

// File: rtl/qenc_counter.sv
// Module: top of the encoder counter channel. Selects the count source by
// mode, runs the synchronized encoder decoder, the counter core and the
// general registers, and keeps sticky flags behind a small register port.
// Assumes enc_a/enc_b are asynchronous; all other inputs are synchronous.
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              cnt_en,
    input  logic              casc_up,
    input  logic              casc_dn,
    input  logic [NUM_GR-1:0] gr_cap_mode,
    input  logic [NUM_GR-1:0] cap_strobe,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [FLAG_W-1:0] irq_flags,
    output logic              ovf_out,
    output logic              unf_out
);
    logic [1:0]        enc_sync;
    logic              dec_up, dec_dn, dec_bad;
    logic              src_up, src_dn, src_bad;
    logic              wr_cnt;
    logic [CNT_W-1:0]  cnt, cnt_next;
    logic              stepped;
    logic [CNT_W-1:0]  gr_val [NUM_GR];
    logic [NUM_GR-1:0] gr_hit;
    logic [FLAG_W-1:0] flags_q, flag_set, flag_clr;
    qenc_mode_e        mode_e;

    assign mode_e = qenc_mode_e'(mode);
    assign wr_cnt = reg_we && (reg_addr == ADDR_CNT);

    qenc_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b}), .q(enc_sync)
    );

    qenc_phase_dec u_dec (
        .clk(clk), .rst_n(rst_n), .ph_a(enc_sync[1]), .ph_b(enc_sync[0]),
        .step_up(dec_up), .step_dn(dec_dn), .illegal(dec_bad)
    );

    // Purpose: choose the count source for the active mode.
    always_comb begin
        src_up  = 1'b0;
        src_dn  = 1'b0;
        src_bad = 1'b0;
        case (mode_e)
            MODE_NORMAL:  src_up = cnt_en;
            MODE_PHASE: begin
                src_up  = dec_up;
                src_dn  = dec_dn;
                src_bad = dec_bad;
            end
            MODE_CASCADE: begin
                src_up = casc_up;
                src_dn = casc_dn;
            end
            default: ;
        endcase
    end

    qenc_count_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .up(src_up), .dn(src_dn),
        .ld(wr_cnt), .ld_val(reg_wdata), .cnt(cnt), .cnt_next(cnt_next),
        .stepped(stepped), .wrap_hi(ovf_out), .wrap_lo(unf_out)
    );

    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        logic wr_this;
        assign wr_this = reg_we && (reg_addr == 2'(g + 1));
        qenc_gen_reg #(.W(CNT_W)) u_gr (
            .clk(clk), .rst_n(rst_n), .cap_mode(gr_cap_mode[g]),
            .cap_strobe(cap_strobe[g]), .stepped(stepped), .cnt_cur(cnt),
            .cnt_next(cnt_next), .we(wr_this), .wdata(reg_wdata),
            .val(gr_val[g]), .hit(gr_hit[g])
        );
    end

    // Purpose: gather flag set events and software clears.
    always_comb begin
        flag_set = '0;
        flag_set[NUM_GR-1:0] = gr_hit;
        flag_set[FLAG_OVF]   = ovf_out;
        flag_set[FLAG_UNF]   = unf_out;
        flag_set[FLAG_ERR]   = src_bad;
        flag_clr = (reg_we && reg_addr == ADDR_FLAG) ? reg_wdata[FLAG_W-1:0] : '0;
    end

    // Purpose: sticky flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign irq_flags = flags_q;

    // Purpose: read mux for the register port.
    always_comb begin
        case (reg_addr)
            ADDR_CNT:  reg_rdata = cnt;
            ADDR_GR0:  reg_rdata = gr_val[0];
            ADDR_GR1:  reg_rdata = gr_val[1];
            default:   reg_rdata = CNT_W'(flags_q);
        endcase
    end

    // R10: a flag stays set unless it is cleared
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FLAG_ERR] && !flag_clr[FLAG_ERR]) |=> irq_flags[FLAG_ERR]);
    // R11: in normal mode with no enable and no write the counter holds
    assert_normal_ignores_enc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_NORMAL && !cnt_en && !wr_cnt) |=> $stable(cnt));
    // R11: in phase mode the counter moves only on decoder steps
    assert_phase_ignores_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_PHASE && !dec_up && !dec_dn && !wr_cnt) |=> $stable(cnt));
    // R5: wrap pulses are never both active
    assert_no_dual_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_out && unf_out));
endmodule

// File: tb/tb_qenc_counter.sv
// Bench: directed corner cases plus a seeded random encoder walk, with a
// second channel in cascade mode carrying the upper 16 bits.
module tb_qenc_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        cnt_en = 1'b0, casc_up = 1'b0, casc_dn = 1'b0;
    logic [1:0]  gr_cap_mode = 2'b00, cap_strobe = 2'b00;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata, hi_rdata;
    logic [4:0]  irq_flags, hi_flags;
    logic        ovf_out, unf_out, hi_ovf, hi_unf;

    int nvec = 0, nfail = 0;
    bit done = 0;

    // bench model
    logic [15:0] exp_cnt = 0, exp_hi = 0;
    logic [4:0]  exp_flags = 0;
    logic [15:0] exp_gr [2] = '{16'h0, 16'h0};
    int          pos = 0;

    always #2 clk = ~clk;

    qenc_counter dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .enc_a(enc_a), .enc_b(enc_b),
        .cnt_en(cnt_en), .casc_up(casc_up), .casc_dn(casc_dn),
        .gr_cap_mode(gr_cap_mode), .cap_strobe(cap_strobe), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_flags(irq_flags), .ovf_out(ovf_out), .unf_out(unf_out)
    );

    qenc_counter u_hi (
        .clk(clk), .rst_n(rst_n), .mode(2'b10), .enc_a(1'b0), .enc_b(1'b0),
        .cnt_en(1'b0), .casc_up(ovf_out), .casc_dn(unf_out),
        .gr_cap_mode(2'b00), .cap_strobe(2'b00), .reg_we(1'b0),
        .reg_addr(2'd0), .reg_wdata(16'h0), .reg_rdata(hi_rdata),
        .irq_flags(hi_flags), .ovf_out(hi_ovf), .unf_out(hi_unf)
    );

    function automatic logic [1:0] gray(input int p);
        case (p & 3)
            0: gray = 2'b00;
            1: gray = 2'b10;
            2: gray = 2'b11;
            default: gray = 2'b01;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_step(input bit up, input bit dn);
        if (up) begin
            if (exp_cnt == 16'hFFFF) begin exp_flags[2] = 1; exp_hi++; end
            exp_cnt++;
        end else if (dn) begin
            if (exp_cnt == 16'h0000) begin exp_flags[3] = 1; exp_hi--; end
            exp_cnt--;
        end
        if (up || dn)
            for (int i = 0; i < 2; i++)
                if (!gr_cap_mode[i] && exp_cnt == exp_gr[i]) exp_flags[i] = 1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        case (a)
            2'd0: exp_cnt = d;
            2'd1: exp_gr[0] = d;
            2'd2: exp_gr[1] = d;
            default: exp_flags = exp_flags & ~d[4:0];
        endcase
    endtask

    // move encoder to new gray position and let it settle (4 edges)
    task automatic enc_move(input int np);
        logic [1:0] g;
        @(negedge clk);
        g = gray(np);
        enc_a = g[1]; enc_b = g[0];
        pos = np & 3;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        rd(2'd0, v);
        check(req, {16'h0, v}, {16'h0, exp_cnt});
        check(req, {27'h0, irq_flags}, {27'h0, exp_flags});
        check({req, " upper"}, {16'h0, hi_rdata}, {16'h0, exp_hi});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check("R1 cnt", {16'h0, v}, 0);
        rd(2'd1, v); check("R1 gr0", {16'h0, v}, 0);
        rd(2'd2, v); check("R1 gr1", {16'h0, v}, 0);
        rd(2'd3, v); check("R1 flags", {16'h0, v}, 0);
        check("R1 upper", {16'h0, hi_rdata}, 0);

        // R2: normal count for 10 cycles
        @(negedge clk); cnt_en = 1;
        repeat (10) begin @(negedge clk); model_step(1, 0); end
        cnt_en = 0;
        check_all("R2 normal count");

        // R11: encoder ignored in normal mode
        enc_move(pos + 1);
        enc_move(pos + 1);
        check_all("R11 enc ignored");
        // R11: cnt_en ignored in phase mode
        @(negedge clk); mode = 2'b01; cnt_en = 1;
        repeat (6) @(negedge clk);
        cnt_en = 0;
        check_all("R11 en ignored");

        // R3: latency of exactly three edges
        @(negedge clk);
        begin
            logic [1:0] g;
            g = gray(pos + 1);
            enc_a = g[1]; enc_b = g[0];
            pos = (pos + 1) & 3;
        end
        @(negedge clk); @(negedge clk);
        rd(2'd0, v); check("R3 not yet at 2nd edge", {16'h0, v}, {16'h0, exp_cnt});
        @(negedge clk);
        model_step(1, 0);
        rd(2'd0, v); check("R3 at 3rd edge", {16'h0, v}, {16'h0, exp_cnt});
        // R3: full up cycle and full down cycle
        for (int i = 0; i < 4; i++) begin enc_move(pos + 1); model_step(1, 0); end
        check_all("R3 up cycle");
        for (int i = 0; i < 6; i++) begin enc_move(pos + 3); model_step(0, 1); end
        check_all("R3 down cycle");

        // R4: illegal double change
        enc_move(pos + 2);
        exp_flags[4] = 1;
        check_all("R4 illegal");

        // R10: clear all flags
        wr(2'd3, 16'h001F);
        check_all("R10 clear flags");

        // R5 / R7: overflow into upper channel
        wr(2'd0, 16'hFFFF);
        enc_move(pos + 1); model_step(1, 0);
        check_all("R5 overflow");
        // R6 / R7: underflow out of upper channel
        enc_move(pos + 3); model_step(0, 1);
        check_all("R6 underflow");

        // R8: compare hit on the landing step
        wr(2'd1, 16'h0105);
        wr(2'd0, 16'h0100);
        wr(2'd3, 16'h001F);
        @(negedge clk); mode = 2'b00; cnt_en = 1;
        repeat (4) begin @(negedge clk); model_step(1, 0); end
        cnt_en = 0;
        check_all("R8 before match");
        @(negedge clk); cnt_en = 1;
        @(negedge clk); cnt_en = 0; model_step(1, 0);
        check_all("R8 compare match");

        // R9: capture into GR1
        wr(2'd3, 16'h001F);
        gr_cap_mode = 2'b10;
        wr(2'd0, 16'h1234);
        @(negedge clk); cap_strobe = 2'b10;
        @(negedge clk); cap_strobe = 2'b00;
        exp_gr[1] = 16'h1234; exp_flags[1] = 1;
        rd(2'd2, v); check("R9 capture value", {16'h0, v}, 32'h1234);
        check_all("R9 capture flag");
        gr_cap_mode = 2'b00;

        // R10: write beats a count in the same cycle
        @(negedge clk);
        reg_we = 1; reg_addr = 2'd0; reg_wdata = 16'h0777; cnt_en = 1;
        @(negedge clk);
        reg_we = 0; cnt_en = 0; exp_cnt = 16'h0777;
        check_all("R10 write priority");

        // R7: direct cascade inputs
        @(negedge clk); mode = 2'b10; casc_up = 1;
        repeat (3) begin @(negedge clk); model_step(1, 0); end
        casc_up = 0; casc_dn = 1;
        @(negedge clk); model_step(0, 1);
        casc_dn = 0;
        check_all("R7 cascade inputs");

        // R3/R4/R5/R6: random walk crossing both wrap points
        @(negedge clk); mode = 2'b01;
        wr(2'd0, 16'hFFF8);
        wr(2'd3, 16'h001F);
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 8;
            if (i == 200) begin wr(2'd0, 16'h0004); end
            if (r < 3)       begin enc_move(pos + 1); model_step(1, 0); end
            else if (r < 6)  begin enc_move(pos + 3); model_step(0, 1); end
            else if (r == 6) begin enc_move(pos + 2); exp_flags[4] = 1; end
            else             begin repeat (2) @(negedge clk); end
            if (i % 20 == 19) check_all("R3 random walk");
            else begin
                rd(2'd0, v);
                check("R3 random cnt", {16'h0, v}, {16'h0, exp_cnt});
            end
        end
        check_all("R5 R6 random end");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule